// File: doc/BRIEF.md
# USB Host IN Pipe Request Engine

One instance of this engine sits behind each host pipe. It decides, on every token slot the scheduler offers, whether the pipe sends an IN token. It keeps the data PID it expects for the next packet, and it raises the received-data flags when a bank fills. Packet transmission, the FIFO memory and the scheduler live outside the block.

Software clears the freeze state to start the pipe. In finite mode the engine sends the programmed count plus one requests and then freezes the pipe by itself. In endless mode it keeps sending until software freezes the pipe. On control pipes, each change of token stage reloads the data toggle to its start value.

Top module: `usb_in_pipe_engine`

## Requirements
- R1: After reset the pipe is frozen (`frozen_o`=1), `data_pid_o` is 0 (DATA0), and `rxin_flag_o`, `fifocon_o` and `pipe_irq_o` are 0.
- R2: `in_req_o` is high only in a cycle where `slot_i` is high and the pipe is not frozen; while frozen no request is issued.
- R3: With `in_mode_i`=0, after unfreezing with count N, exactly N+1 requests are issued. `frozen_o` is 1 from the cycle after the last request.
- R4: With `in_mode_i`=1, every offered slot produces a request, and the pipe stays unfrozen until `freeze_set_i`.
- R5: No request is issued while `fifocon_o` is 1 (the bank is full).
- R6: A cycle with `rx_valid_i` and `rx_full_i` both high sets `rxin_flag_o` and `fifocon_o` together, visible in the next cycle.
- R7: `pipe_irq_o` is high exactly when `rxin_flag_o` and `rxin_en_i` are both high.
- R8: A `rxin_clr_i` pulse clears `rxin_flag_o` only; `fifocon_o` and request blocking stay unchanged.
- R9: On a control pipe (`pipe_ctrl_i`=1), a change of `stage_i` (00 SETUP, 01 IN, 10 OUT) sets `data_pid_o` in the next cycle: 0 for SETUP, 1 for IN or OUT.
- R10: Each `rx_valid_i` cycle inverts `data_pid_o` for the next cycle. A non-control pipe starts from DATA0 after reset.
- R11: A `freeze_set_i` pulse in the middle of a finite count stops requests. The next `freeze_clr_i` reloads the count, so N+1 further requests follow.
- R12: A `fifo_rel_i` pulse clears `fifocon_o` in the next cycle, and requests resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_set_i | input | 1 | Freeze the pipe (pulse) |
| freeze_clr_i | input | 1 | Unfreeze the pipe and reload the count (pulse) |
| in_mode_i | input | 1 | 0 finite, 1 endless |
| in_count_i | input | CNT_W | Request count N (N+1 requests are sent) |
| pipe_ctrl_i | input | 1 | Pipe is a control pipe |
| stage_i | input | 2 | Control stage: 00 SETUP, 01 IN, 10 OUT |
| slot_i | input | 1 | Token slot offered by the scheduler |
| rx_valid_i | input | 1 | Data packet received without error |
| rx_full_i | input | 1 | That packet filled the current bank |
| rxin_clr_i | input | 1 | Clear the received-IN flag (pulse) |
| fifo_rel_i | input | 1 | Release the bank, clearing FIFO control (pulse) |
| rxin_en_i | input | 1 | Received-IN interrupt enable |
| in_req_o | output | 1 | Send an IN token in this slot |
| data_pid_o | output | 1 | Expected data PID: 0 DATA0, 1 DATA1 |
| rxin_flag_o | output | 1 | Received-IN interrupt flag |
| fifocon_o | output | 1 | FIFO control: bank full, held for software |
| frozen_o | output | 1 | Pipe freeze state |
| pipe_irq_o | output | 1 | Pipe interrupt |

## Verification
The hardest case to reach is a freeze in the middle of a finite count, followed by a reload. The count must be partly used, and the self-freeze must not have fired yet. The bench unfreezes with N=3, spends two slots, forces a freeze, and then proves that an unfreeze gives four full requests. The scoreboard expects a request in each of those slots, then a self-freeze and a refused slot. Bank-full blocking is reached by filling the bank in endless mode and offering slots before and after the flag clear and the bank release.

// File: rtl/usb_pipe_pkg.sv
package usb_pipe_pkg;
  typedef enum logic [1:0] {
    STG_SETUP = 2'b00,
    STG_IN    = 2'b01,
    STG_OUT   = 2'b10
  } stage_e;

  localparam logic PID_DATA0 = 1'b0;
  localparam logic PID_DATA1 = 1'b1;

  function automatic logic stage_init_pid(input logic [1:0] stg);
    return (stg == STG_SETUP) ? PID_DATA0 : PID_DATA1;
  endfunction
endpackage

// File: rtl/pipe_req_ctrl.sv
module pipe_req_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_set_i,
  input  logic             freeze_clr_i,
  input  logic             in_mode_i,
  input  logic [CNT_W-1:0] in_count_i,
  input  logic             slot_i,
  input  logic             bank_full_i,
  output logic             in_req_o,
  output logic             frozen_o,
  output logic [CNT_W-1:0] rem_o
);
  logic             frozen_q;
  logic [CNT_W-1:0] rem_q;
  logic             last_req;

  assign in_req_o = slot_i && !frozen_q && !bank_full_i;
  assign last_req = in_req_o && !in_mode_i && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frozen_q <= 1'b1;
      rem_q    <= '0;
    end else if (freeze_set_i) begin
      frozen_q <= 1'b1;
    end else if (freeze_clr_i) begin
      frozen_q <= 1'b0;
      rem_q    <= in_count_i;
    end else if (last_req) begin
      frozen_q <= 1'b1;
    end else if (in_req_o && !in_mode_i) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign frozen_o = frozen_q;
  assign rem_o    = rem_q;
endmodule

// File: rtl/pipe_toggle.sv
module pipe_toggle
  import usb_pipe_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pipe_ctrl_i,
  input  logic [1:0] stage_i,
  input  logic       rx_valid_i,
  output logic       pid_o
);
  logic [1:0] stage_q;
  logic       pid_q;
  logic       stage_chg;

  assign stage_chg = pipe_ctrl_i && (stage_i != stage_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= STG_SETUP;
      pid_q   <= PID_DATA0;
    end else begin
      stage_q <= stage_i;
      if (stage_chg)       pid_q <= stage_init_pid(stage_i);
      else if (rx_valid_i) pid_q <= ~pid_q;
    end
  end

  assign pid_o = pid_q;
endmodule

// File: rtl/pipe_rx_flags.sv
module pipe_rx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_valid_i,
  input  logic rx_full_i,
  input  logic rxin_clr_i,
  input  logic fifo_rel_i,
  input  logic rxin_en_i,
  output logic rxin_o,
  output logic fifocon_o,
  output logic irq_o
);
  logic rxin_q, fifocon_q, fill;

  assign fill = rx_valid_i && rx_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxin_q    <= 1'b0;
      fifocon_q <= 1'b0;
    end else begin
      if (fill)            rxin_q <= 1'b1;
      else if (rxin_clr_i) rxin_q <= 1'b0;
      if (fill)            fifocon_q <= 1'b1;
      else if (fifo_rel_i) fifocon_q <= 1'b0;
    end
  end

  assign rxin_o    = rxin_q;
  assign fifocon_o = fifocon_q;
  assign irq_o     = rxin_q && rxin_en_i;
endmodule

// File: rtl/usb_in_pipe_engine.sv
module usb_in_pipe_engine #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             freeze_set_i,
  input  logic             freeze_clr_i,
  input  logic             in_mode_i,
  input  logic [CNT_W-1:0] in_count_i,
  input  logic             pipe_ctrl_i,
  input  logic [1:0]       stage_i,
  input  logic             slot_i,
  input  logic             rx_valid_i,
  input  logic             rx_full_i,
  input  logic             rxin_clr_i,
  input  logic             fifo_rel_i,
  input  logic             rxin_en_i,
  output logic             in_req_o,
  output logic             data_pid_o,
  output logic             rxin_flag_o,
  output logic             fifocon_o,
  output logic             frozen_o,
  output logic             pipe_irq_o
);
  logic [CNT_W-1:0] rem_cnt;

  pipe_req_ctrl #(.CNT_W(CNT_W)) u_req (
    .clk_i, .rst_ni, .freeze_set_i, .freeze_clr_i, .in_mode_i, .in_count_i,
    .slot_i, .bank_full_i(fifocon_o), .in_req_o, .frozen_o, .rem_o(rem_cnt)
  );

  pipe_toggle u_tog (
    .clk_i, .rst_ni, .pipe_ctrl_i, .stage_i, .rx_valid_i, .pid_o(data_pid_o)
  );

  pipe_rx_flags u_flags (
    .clk_i, .rst_ni, .rx_valid_i, .rx_full_i, .rxin_clr_i, .fifo_rel_i,
    .rxin_en_i, .rxin_o(rxin_flag_o), .fifocon_o, .irq_o(pipe_irq_o)
  );
endmodule

// File: rtl/usb_in_pipe_chk.sv
module usb_in_pipe_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             freeze_set_i,
  input logic             freeze_clr_i,
  input logic             in_mode_i,
  input logic             rx_valid_i,
  input logic             rx_full_i,
  input logic             rxin_clr_i,
  input logic             fifo_rel_i,
  input logic             in_req_o,
  input logic             rxin_flag_o,
  input logic             fifocon_o,
  input logic             frozen_o,
  input logic [CNT_W-1:0] rem_cnt
);
  p_no_req_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_o |-> !in_req_o);

  p_self_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req_o && !in_mode_i && rem_cnt == '0 && !freeze_clr_i) |=> frozen_o);

  p_endless_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req_o && in_mode_i && !freeze_set_i) |=> !frozen_o);

  p_no_req_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifocon_o |-> !in_req_o);

  p_flags_together_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_full_i) |=> (rxin_flag_o && fifocon_o));

  p_clr_keeps_fifo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxin_clr_i && !fifo_rel_i && !(rx_valid_i && rx_full_i))
      |=> (!rxin_flag_o && fifocon_o == $past(fifocon_o)));
endmodule

bind usb_in_pipe_engine usb_in_pipe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .freeze_set_i(freeze_set_i),
  .freeze_clr_i(freeze_clr_i), .in_mode_i(in_mode_i), .rx_valid_i(rx_valid_i),
  .rx_full_i(rx_full_i), .rxin_clr_i(rxin_clr_i), .fifo_rel_i(fifo_rel_i),
  .in_req_o(in_req_o), .rxin_flag_o(rxin_flag_o), .fifocon_o(fifocon_o),
  .frozen_o(frozen_o), .rem_cnt(rem_cnt)
);

// File: tb/tb_usb_in_pipe_engine.sv
module tb_usb_in_pipe_engine;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic freeze_set_i = 0, freeze_clr_i = 0, in_mode_i = 0, pipe_ctrl_i = 0;
  logic [CNT_W-1:0] in_count_i = '0;
  logic [1:0] stage_i = 2'b00;
  logic slot_i = 0, rx_valid_i = 0, rx_full_i = 0, rxin_clr_i = 0;
  logic fifo_rel_i = 0, rxin_en_i = 0;
  logic in_req_o, data_pid_o, rxin_flag_o, fifocon_o, frozen_o, pipe_irq_o;

  int n_tests = 0, n_fail = 0;
  logic exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  usb_in_pipe_engine #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni, .freeze_set_i, .freeze_clr_i, .in_mode_i, .in_count_i,
    .pipe_ctrl_i, .stage_i, .slot_i, .rx_valid_i, .rx_full_i, .rxin_clr_i,
    .fifo_rel_i, .rxin_en_i, .in_req_o, .data_pid_o, .rxin_flag_o, .fifocon_o,
    .frozen_o, .pipe_irq_o
  );

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // monitor: compares in_req_o against scoreboard on each offered slot
  initial forever begin
    @(negedge clk); #2;
    if (slot_i) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard: got %b expected none", in_req_o);
      end else check(tag_q.pop_front(), in_req_o, exp_q.pop_front());
    end
  end

  task automatic offer(string req, logic exp);
    @(negedge clk);
    slot_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    slot_i = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic recv(logic full);
    @(negedge clk); rx_valid_i = 1'b1; rx_full_i = full;
    @(negedge clk); rx_valid_i = 1'b0; rx_full_i = 1'b0;
  endtask

  task automatic set_stage(logic [1:0] s);
    @(negedge clk); stage_i = s;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 frozen", frozen_o, 1'b1);
    check("R1 pid", data_pid_o, 1'b0);
    check("R1 rxin", rxin_flag_o, 1'b0);
    check("R1 fifocon", fifocon_o, 1'b0);
    check("R1 irq", pipe_irq_o, 1'b0);

    offer("R2 frozen slot", 1'b0);

    // R3 finite mode, N=2
    in_count_i = 8'd2; in_mode_i = 1'b0;
    pulse(freeze_clr_i);
    check("R3 unfrozen", frozen_o, 1'b0);
    for (int i = 0; i < 3; i++) offer("R3 counted req", 1'b1);
    check("R3 self frozen", frozen_o, 1'b1);
    offer("R3 after count", 1'b0);

    // R4 endless mode
    in_mode_i = 1'b1;
    pulse(freeze_clr_i);
    for (int i = 0; i < 5; i++) offer("R4 endless req", 1'b1);
    check("R4 still unfrozen", frozen_o, 1'b0);

    // R6/R7/R10 bank fill
    rxin_en_i = 1'b1;
    recv(1'b1);
    check("R6 rxin", rxin_flag_o, 1'b1);
    check("R6 fifocon", fifocon_o, 1'b1);
    check("R7 irq on", pipe_irq_o, 1'b1);
    check("R10 pid toggled", data_pid_o, 1'b1);
    offer("R5 bank full", 1'b0);
    rxin_en_i = 1'b0; #1;
    check("R7 irq masked", pipe_irq_o, 1'b0);
    rxin_en_i = 1'b1;

    // R8 clear flag only
    pulse(rxin_clr_i);
    check("R8 rxin cleared", rxin_flag_o, 1'b0);
    check("R8 fifocon kept", fifocon_o, 1'b1);
    check("R7 irq off", pipe_irq_o, 1'b0);
    offer("R8 still blocked", 1'b0);

    // R12 release
    pulse(fifo_rel_i);
    check("R12 fifocon cleared", fifocon_o, 1'b0);
    offer("R12 resumes", 1'b1);

    recv(1'b0);
    check("R10 pid back", data_pid_o, 1'b0);
    check("R10 no flag", rxin_flag_o, 1'b0);

    // R9 control stages
    pipe_ctrl_i = 1'b1;
    set_stage(2'b01);
    check("R9 IN stage DATA1", data_pid_o, 1'b1);
    recv(1'b0);
    check("R10 ctrl toggle", data_pid_o, 1'b0);
    set_stage(2'b10);
    check("R9 OUT stage DATA1", data_pid_o, 1'b1);
    set_stage(2'b00);
    check("R9 SETUP stage DATA0", data_pid_o, 1'b0);
    recv(1'b0);
    check("R10 setup toggle", data_pid_o, 1'b1);

    // R11 freeze mid count, reload
    pulse(freeze_set_i);
    check("R11 frozen", frozen_o, 1'b1);
    in_mode_i = 1'b0; in_count_i = 8'd3;
    pulse(freeze_clr_i);
    offer("R11 first", 1'b1);
    offer("R11 second", 1'b1);
    pulse(freeze_set_i);
    offer("R11 frozen mid", 1'b0);
    pulse(freeze_clr_i);
    for (int i = 0; i < 4; i++) offer("R11 reloaded", 1'b1);
    check("R11 self frozen", frozen_o, 1'b1);
    offer("R11 done", 1'b0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: got %0d left expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule